// File: doc/BRIEF.md
# Width-Polymorphic Integer Add Unit

This unit adds two integers whose sources and destination each carry their own element width of 8, 16, 32 or 64 bits. It serves a 64-bit datapath that runs element-width-tagged arithmetic. The unit supports four operation forms: a plain register add, a register add that sign-extends its sources, a fixed-width immediate add on 32 bits, and an immediate add whose width follows the source.

For each form the unit works out how every operand is extended and the internal width of the addition. It then sign-extends or truncates the sum to fit the destination width. Bits of the result above the destination width are forced to zero.

The result is captured in a register. A small two-state controller tracks whether that register holds a fresh result. The state is `ST_EMPTY` (no result presented) or `ST_LOADED` (a result is presented). On every clock, an accepted input (`in_valid` high) moves the controller to `ST_LOADED`. A cycle with no input moves it to `ST_EMPTY`. Synchronous reset forces `ST_EMPTY`.

Top module: `poly_add_unit`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0 and `result` is 0.
- R2: An input accepted with `in_valid`=1 at a clock edge yields `out_valid`=1 and its result after that edge. A clock edge with `in_valid`=0 drives `out_valid` to 0 and leaves `result` unchanged.
- R3: Width code 00 means 8 bits, 01 means 16, 10 means 32 and 11 means 64. In forms that use a source's width code, bits of that source above its width have no effect on the result.
- R4: With `in_op`=00 (plain add), both sources are zero-extended to the destination width, or truncated to it. They are then added at the destination width.
- R5: With `in_op`=01 (sign-extending add) and equal source width codes, the sources are added at their common width without extension. That sum is sign-extended to the destination width when the destination is wider, and truncated otherwise.
- R6: With `in_op`=01 and differing source width codes, each source is sign-extended from its own width. Both are then added at the destination width.
- R7: With `in_op`=10 (fixed immediate add), the low 32 bits of `src_a` are added to the sign-extended 12-bit immediate at 32 bits. The 32-bit sum is sign-extended to the destination when it is wider than 32, and truncated otherwise. `src_a_wc` is ignored in this form.
- R8: With `in_op`=11 (width-following immediate add), let M be the larger of the source A width and 12. Source A and the immediate are both sign-extended to M bits and added at M bits. The sum is sign-extended when the destination is wider than M, and truncated otherwise.
- R9: All `result` bits at or above the destination width are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and operation are present this cycle |
| in_op | input | 2 | Operation form: 00 add, 01 sign-extending add, 10 fixed immediate add, 11 width-following immediate add |
| src_a | input | 64 | First source value |
| src_a_wc | input | 2 | Width code of the first source |
| src_b | input | 64 | Second source value (register forms) |
| src_b_wc | input | 2 | Width code of the second source |
| imm | input | 12 | Immediate (immediate forms) |
| dst_wc | input | 2 | Width code of the destination |
| out_valid | output | 1 | `result` holds a fresh sum |
| result | output | 64 | Sum fitted to the destination width |

## Verification
Capturing a new operand set and presenting the previous result fall in the same clock cycle whenever inputs arrive back to back. The bench provokes this by sweeping every form and width combination with `in_valid` held high. Each cycle it judges the presented result against a model of the operation issued one cycle earlier. It also judges the fall of `out_valid`, together with an unchanged `result`, in the first idle cycle after such a burst.

// File: rtl/poly_add_pkg.sv
package poly_add_pkg;

    localparam int XLEN  = 64;
    localparam int IMM_W = 12;
    localparam int WC_W  = 2;
    localparam int BW_W  = $clog2(XLEN) + 1;

    typedef enum logic [1:0] {
        OP_ADD     = 2'b00,
        OP_ADDW_P  = 2'b01,
        OP_ADDIW_F = 2'b10,
        OP_ADDIW_P = 2'b11
    } op_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } ctrl_state_e;

    function automatic logic [BW_W-1:0] wc_bits(input logic [WC_W-1:0] wc);
        return BW_W'(8) << wc;
    endfunction

    function automatic logic [XLEN-1:0] sext_to(input logic [XLEN-1:0] v,
                                                input logic [BW_W-1:0] w);
        logic [BW_W-1:0] sh;
        logic [XLEN-1:0] t;
        sh = BW_W'(XLEN) - w;
        t  = v << sh;
        return XLEN'($signed(t) >>> sh);
    endfunction

    function automatic logic [XLEN-1:0] mask_to(input logic [XLEN-1:0] v,
                                                input logic [BW_W-1:0] w);
        if (w >= BW_W'(XLEN)) return v;
        return v & ((XLEN'(1) << w) - XLEN'(1));
    endfunction

endpackage

// File: rtl/poly_add_operand.sv
module poly_add_operand
    import poly_add_pkg::*;
(
    input  logic [1:0]       op,
    input  logic [XLEN-1:0]  a,
    input  logic [WC_W-1:0]  a_wc,
    input  logic [XLEN-1:0]  b,
    input  logic [WC_W-1:0]  b_wc,
    input  logic [IMM_W-1:0] imm,
    input  logic [WC_W-1:0]  d_wc,
    output logic [XLEN-1:0]  opa,
    output logic [XLEN-1:0]  opb,
    output logic [BW_W-1:0]  add_w,
    output logic [BW_W-1:0]  dst_w
);
    logic [BW_W-1:0] wa, wb, wd;
    logic [XLEN-1:0] imm_x;

    always_comb begin
        wa    = wc_bits(a_wc);
        wb    = wc_bits(b_wc);
        wd    = wc_bits(d_wc);
        imm_x = sext_to(XLEN'(imm), BW_W'(IMM_W));
        dst_w = wd;
        unique case (op_e'(op))
            OP_ADD: begin
                opa   = mask_to(mask_to(a, wa), wd);
                opb   = mask_to(mask_to(b, wb), wd);
                add_w = wd;
            end
            OP_ADDW_P: begin
                if (a_wc == b_wc) begin
                    opa   = mask_to(a, wa);
                    opb   = mask_to(b, wa);
                    add_w = wa;
                end else begin
                    opa   = sext_to(a, wa);
                    opb   = sext_to(b, wb);
                    add_w = wd;
                end
            end
            OP_ADDIW_F: begin
                opa   = mask_to(a, BW_W'(32));
                opb   = imm_x;
                add_w = BW_W'(32);
            end
            OP_ADDIW_P: begin
                opa   = sext_to(a, wa);
                opb   = imm_x;
                add_w = (wa < BW_W'(IMM_W)) ? BW_W'(IMM_W) : wa;
            end
            default: begin
                opa   = '0;
                opb   = '0;
                add_w = wd;
            end
        endcase
    end
endmodule

// File: rtl/poly_add_core.sv
module poly_add_core
    import poly_add_pkg::*;
(
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [BW_W-1:0] add_w,
    input  logic [BW_W-1:0] dst_w,
    output logic [XLEN-1:0] fitted
);
    logic [XLEN-1:0] raw_sum;
    logic [XLEN-1:0] wrapped;

    always_comb begin
        raw_sum = opa + opb;
        wrapped = sext_to(raw_sum, add_w);
        fitted  = mask_to(wrapped, dst_w);
    end
endmodule

// File: rtl/poly_add_ctrl.sv
module poly_add_ctrl
    import poly_add_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [XLEN-1:0] fitted,
    output logic            out_valid,
    output logic [XLEN-1:0] result
);
    ctrl_state_e state_q, state_d;
    logic [XLEN-1:0] result_q;

    always_comb begin
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_EMPTY;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) result_q <= fitted;
        end
    end

    always_comb begin
        out_valid = (state_q == ST_LOADED);
        result    = result_q;
    end

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    valid_drops_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
endmodule

// File: rtl/poly_add_unit.sv
module poly_add_unit
    import poly_add_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic [XLEN-1:0]  src_a,
    input  logic [WC_W-1:0]  src_a_wc,
    input  logic [XLEN-1:0]  src_b,
    input  logic [WC_W-1:0]  src_b_wc,
    input  logic [IMM_W-1:0] imm,
    input  logic [WC_W-1:0]  dst_wc,
    output logic             out_valid,
    output logic [XLEN-1:0]  result
);
    logic [XLEN-1:0] opa, opb, fitted;
    logic [BW_W-1:0] add_w, dst_w;

    poly_add_operand u_operand (
        .op(in_op), .a(src_a), .a_wc(src_a_wc), .b(src_b), .b_wc(src_b_wc),
        .imm(imm), .d_wc(dst_wc), .opa(opa), .opb(opb),
        .add_w(add_w), .dst_w(dst_w)
    );

    poly_add_core u_core (
        .opa(opa), .opb(opb), .add_w(add_w), .dst_w(dst_w), .fitted(fitted)
    );

    poly_add_ctrl u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fitted(fitted),
        .out_valid(out_valid), .result(result)
    );

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dst_wc != 2'b11) |=>
            ((result >> (8 << $past(dst_wc))) == '0));
    // R7
    fixed_imm_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b10 && dst_wc[1]) |=>
            (result[31:0] == $past(src_a[31:0] + {{20{imm[11]}}, imm})));
    // R4
    plain_full_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b00 && src_a_wc == 2'b11 &&
         src_b_wc == 2'b11 && dst_wc == 2'b11) |=>
            (result == $past(src_a + src_b)));
endmodule

// File: tb/poly_add_unit_bench.sv
module poly_add_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [63:0] src_a = '0, src_b = '0;
    logic [1:0]  src_a_wc = 2'b00, src_b_wc = 2'b00, dst_wc = 2'b00;
    logic [11:0] imm = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    poly_add_unit u_poly_add_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .src_a(src_a), .src_a_wc(src_a_wc), .src_b(src_b), .src_b_wc(src_b_wc),
        .imm(imm), .dst_wc(dst_wc), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] zx(input logic [63:0] v, input int n);
        case (n)
            8:       return {56'd0, v[7:0]};
            12:      return {52'd0, v[11:0]};
            16:      return {48'd0, v[15:0]};
            32:      return {32'd0, v[31:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [63:0] sx(input logic [63:0] v, input int n);
        case (n)
            8:       return {{56{v[7]}}, v[7:0]};
            12:      return {{52{v[11]}}, v[11:0]};
            16:      return {{48{v[15]}}, v[15:0]};
            32:      return {{32{v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] a,
        input logic [1:0] wa, input logic [63:0] b, input logic [1:0] wb,
        input logic [11:0] im, input logic [1:0] wd);
        int na, nb, nd, m;
        logic [63:0] s;
        na = 8 << wa; nb = 8 << wb; nd = 8 << wd;
        case (op)
            2'b00: s = zx(zx(a, na), nd) + zx(zx(b, nb), nd);
            2'b01: begin
                if (na == nb) s = sx(zx(a, na) + zx(b, na), na);
                else          s = sx(a, na) + sx(b, nb);
            end
            2'b10: s = sx({32'd0, a[31:0]} + sx({52'd0, im}, 12), 32);
            default: begin
                m = (na < 12) ? 12 : na;
                s = sx(sx(a, na) + sx({52'd0, im}, 12), m);
            end
        endcase
        return zx(s, nd);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [63:0] a, input logic [1:0] wa,
        input logic [63:0] b, input logic [1:0] wb, input logic [11:0] im, input logic [1:0] wd);
        in_valid = 1'b1; in_op = op; src_a = a; src_a_wc = wa;
        src_b = b; src_b_wc = wb; imm = im; dst_wc = wd;
    endtask

    task automatic one_op(input string req, input logic [1:0] op, input logic [63:0] a,
        input logic [1:0] wa, input logic [63:0] b, input logic [1:0] wb,
        input logic [11:0] im, input logic [1:0] wd, input logic [63:0] exp);
        @(negedge clk);
        drive(op, a, wa, b, wb, im, wd);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check(req, result, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 result", result, 64'd0);
    endtask

    task automatic t_plain;
        one_op("R4", 2'b00, 64'hFF, 2'b00, 64'h01, 2'b00, 12'd0, 2'b01, 64'h100);
        one_op("R4 trunc", 2'b00, 64'hFFFF, 2'b01, 64'h0002, 2'b01, 12'd0, 2'b00, 64'h01);
        one_op("R3", 2'b00, 64'hABCD_0000_0000_00FF, 2'b00, 64'h1234_0001, 2'b00,
               12'd0, 2'b11, 64'h100);
    endtask

    task automatic t_addw;
        one_op("R5", 2'b01, 64'h7F, 2'b00, 64'h01, 2'b00, 12'd0, 2'b01, 64'hFF80);
        one_op("R5 trunc", 2'b01, 64'h1234, 2'b01, 64'h0001, 2'b01, 12'd0, 2'b00, 64'h35);
        one_op("R6", 2'b01, 64'hFF, 2'b00, 64'h0001, 2'b01, 12'd0, 2'b01, 64'h0000);
        one_op("R6 R3", 2'b01, 64'h55FF, 2'b00, 64'h0000_0002, 2'b10, 12'd0, 2'b11,
               64'h1);
    endtask

    task automatic t_imm;
        one_op("R7", 2'b10, 64'h7FFF_FFFF, 2'b00, 64'h0, 2'b00, 12'd1, 2'b11,
               64'hFFFF_FFFF_8000_0000);
        one_op("R7 trunc", 2'b10, 64'h7FFF_FFFF, 2'b00, 64'h0, 2'b00, 12'd1, 2'b01,
               64'h0);
        one_op("R7 neg", 2'b10, 64'h5_0000_0010, 2'b11, 64'h0, 2'b00, 12'hFFF, 2'b10,
               64'h0F);
        one_op("R8", 2'b11, 64'h7F, 2'b00, 64'h0, 2'b00, 12'h7FF, 2'b01, 64'hF87E);
        one_op("R8 trunc", 2'b11, 64'h7F, 2'b00, 64'h0, 2'b00, 12'h7FF, 2'b00, 64'h7E);
        one_op("R8 wide", 2'b11, 64'hFFFF, 2'b01, 64'h0, 2'b00, 12'h001, 2'b11, 64'h0);
    endtask

    task automatic t_idle_hold;
        logic [63:0] held;
        @(negedge clk);
        held = result;
        drive(2'b00, 64'h1111, 2'b11, 64'h2222, 2'b11, 12'd0, 2'b11);
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 idle valid", {63'd0, out_valid}, 64'd0);
        check("R2 idle hold", result, held);
    endtask

    task automatic t_sweep;
        logic [63:0] prev_exp;
        logic        have_prev;
        logic [63:0] pa [2];
        logic [63:0] pb [2];
        logic [11:0] pi [2];
        pa[0] = 64'h8123_4567_89AB_CDEF; pb[0] = 64'hF0F0_0F0F_7FFF_80FF;
        pi[0] = 12'h801;
        pa[1] = 64'h0000_7FFF_FFFF_7F7F; pb[1] = 64'h7FFF_0000_8000_0181;
        pi[1] = 12'h3C5;
        have_prev = 1'b0;
        prev_exp = '0;
        @(negedge clk);
        for (int p = 0; p < 2; p++)
            for (int op = 0; op < 4; op++)
                for (int wa = 0; wa < 4; wa++)
                    for (int wb = 0; wb < 4; wb++)
                        for (int wd = 0; wd < 4; wd++) begin
                            if (have_prev) begin
                                check("R2 R4 R5 R6 R7 R8 R9 back-to-back", result, prev_exp);
                                check("R2 burst valid", {63'd0, out_valid}, 64'd1);
                            end
                            drive(2'(op), pa[p], 2'(wa), pb[p], 2'(wb), pi[p], 2'(wd));
                            prev_exp = model(2'(op), pa[p], 2'(wa), pb[p], 2'(wb),
                                             pi[p], 2'(wd));
                            have_prev = 1'b1;
                            @(negedge clk);
                        end
        in_valid = 1'b0;
        check("R2 last of burst", result, prev_exp);
        @(negedge clk);
        check("R2 burst end valid", {63'd0, out_valid}, 64'd0);
        check("R2 burst end hold", result, prev_exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain();
        t_addw();
        t_imm();
        t_idle_hold();
        t_sweep();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset again valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset again result", result, 64'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule